// File: doc/BRIEF.md
# Station-Address PROM I/O Window Decoder

This block sits on the slave side of a network controller's I/O register space. A host issues one access at a time, giving an address, a size code and write data. An access in the lowest 16 bytes of the space goes to a 16-byte station-address PROM that is held in flip-flops. An access above that window is passed on to an external register port, which serves it under a ready handshake. A mode input chooses between 16-bit and 32-bit I/O mode, and that choice sets which sizes and alignments the window will serve. A separate enable input gates writes into the PROM. Any read that is not served returns all ones, sized to the request.

The sequencer has three states:
- `ST_IDLE` waits for `req_valid`.
- `ST_FWD` holds a forwarded request until `reg_ready`.
- `ST_RESP` drives the one-cycle `rsp_ready` pulse.

Its transitions are:
- IDLE→RESP when a local or rejected access is accepted.
- IDLE→FWD when a forwarded access is accepted.
- FWD→RESP on `reg_ready`.
- RESP→IDLE always.

Requests are accepted only in `ST_IDLE`. The host keeps `req_valid` high for one cycle and then waits for `rsp_ready`.

Size codes on `req_size` and `reg_size` are:
- 2'b00: 1 byte.
- 2'b01: 2 bytes.
- 2'b10: 4 bytes.
- 2'b11: reserved, never served.

Top module: `aprom_io_decoder`

## Requirements
- R1: After reset, PROM bytes 0..5 hold `STATION_ADDR` least significant byte first (byte 0 = bits [7:0]). Bytes 6..15 hold `FILL_BYTE`. `rsp_ready` and `reg_req` are low.
- R2: With `mode32` = 0, a 1-byte access (code 2'b00) to the window is served at any offset 0x0..0xF.
- R3: With `mode32` = 0, a 2-byte access (code 2'b01) to the window is served only at an even address. An odd address is not served.
- R4: With `mode32` = 1, the window serves only 4-byte accesses (code 2'b10) at addresses whose two low bits are zero. Every other size or alignment there is not served.
- R5: Multi-byte PROM accesses are little-endian. The byte at the lowest address sits on bits [7:0], the next byte on [15:8], and so on. Bits above the access width read as zero.
- R6: A served PROM write changes PROM bytes only while `prom_wr_en` is 1. With `prom_wr_en` = 0 the write is dropped. Reads are never gated.
- R7: An unserved read returns 0x000000FF for code 2'b00, 0x0000FFFF for code 2'b01, and 0xFFFFFFFF for codes 2'b10 and 2'b11.
- R8: An access at address 0x10 or above with code 2'b01 or 2'b10 is forwarded. The port carries the same address and size code, the write flag, and write data masked to the access width. A byte or reserved-size access there is not forwarded.
- R9: `reg_req` stays high with stable address, size, write flag and data until `reg_ready` is sampled high. `rsp_ready` follows one cycle later. The read data is `reg_rdata` masked to the access width.
- R10: For a PROM or unserved access, `rsp_ready` rises in the cycle after the accepting edge. `rsp_ready` is a single-cycle pulse.
- R11: A write that fails the size, alignment or mode rule leaves every PROM byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host access request, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Size code |
| req_wdata | input | 32 | Write data, little-endian lanes |
| mode32 | input | 1 | 1 = 32-bit I/O mode, 0 = 16-bit I/O mode |
| prom_wr_en | input | 1 | Allows PROM writes |
| rsp_ready | output | 1 | Access completion pulse |
| rsp_rdata | output | 32 | Read result, valid with `rsp_ready` |
| reg_req | output | 1 | Forwarded request to the register port |
| reg_write | output | 1 | Write flag of the forwarded request |
| reg_addr | output | ADDR_W | Address of the forwarded request |
| reg_size | output | 2 | Size code of the forwarded request |
| reg_wdata | output | 32 | Width-masked write data of the forwarded request |
| reg_ready | input | 1 | Register port completion |
| reg_rdata | input | 32 | Register port read data |

## Verification
Directed accesses read every PROM byte after reset, which separates the station-address bytes from the fill bytes and exposes any lane-order error. They then target the window edges: odd halves, misaligned words, the wrong size for each mode, and the reserved size code. These cases separate served from rejected accesses and show which all-ones width comes back. Writes with the enable low, and misaligned writes with it high, are each followed by read-back. That read-back separates gated or rejected writes from performed ones. Random accesses over the whole address range, in both modes and with random port delays, compare every response against a byte-array model. This tells the window apart from the forwarded range and checks the delay from `reg_ready` to the response.

// File: rtl/aprom_pkg.sv
package aprom_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_t;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_PROM = 2'd1,
        CLS_FWD  = 2'd2
    } acc_class_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_RESP = 2'd2
    } dec_state_t;

    // Bits of a 32-bit bus covered by an access of the given size.
    function automatic logic [31:0] width_mask(acc_size_t s);
        case (s)
            SZ_BYTE: width_mask = 32'h0000_00FF;
            SZ_HALF: width_mask = 32'h0000_FFFF;
            default: width_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    // Byte lanes touched by an access of the given size.
    function automatic logic [3:0] lane_mask(acc_size_t s);
        case (s)
            SZ_BYTE: lane_mask = 4'b0001;
            SZ_HALF: lane_mask = 4'b0011;
            SZ_WORD: lane_mask = 4'b1111;
            default: lane_mask = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/aprom_classify.sv
module aprom_classify
    import aprom_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int WIN_BYTES = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_t         size,
    input  logic              mode32,
    output acc_class_t        cls
);
    localparam int WIN_IDX_W = $clog2(WIN_BYTES);

    logic in_win;

    assign in_win = (addr >> WIN_IDX_W) == '0;

    always_comb begin
        cls = CLS_NONE;
        if (in_win) begin
            if (!mode32 && size == SZ_BYTE) begin
                cls = CLS_PROM;
            end else if (!mode32 && size == SZ_HALF && !addr[0]) begin
                cls = CLS_PROM;
            end else if (mode32 && size == SZ_WORD && addr[1:0] == 2'b00) begin
                cls = CLS_PROM;
            end
        end else if (size == SZ_HALF || size == SZ_WORD) begin
            cls = CLS_FWD;
        end
    end

endmodule

// File: rtl/aprom_store.sv
module aprom_store #(
    parameter int          WIN_BYTES    = 16,
    parameter logic [47:0] STATION_ADDR = 48'h6655_4433_2211,
    parameter logic [7:0]  FILL_BYTE    = 8'h57
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(WIN_BYTES)-1:0] wr_base,
    input  logic [3:0]                   wr_lanes,
    input  logic [31:0]                  wr_data,
    input  logic [$clog2(WIN_BYTES)-1:0] rd_base,
    output logic [31:0]                  rd_data
);
    localparam int IDX_W = $clog2(WIN_BYTES);
    localparam int SA_BYTES = 6;

    logic [7:0] mem [WIN_BYTES];

    for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
        localparam logic [7:0] INIT =
            (b < SA_BYTES) ? 8'(STATION_ADDR >> (8 * b)) : FILL_BYTE;

        logic [IDX_W-1:0] off;
        logic             hit;

        assign off = IDX_W'(b) - wr_base;
        assign hit = (off < IDX_W'(4)) && wr_lanes[off[1:0]];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[b] <= INIT;
            end else if (hit) begin
                mem[b] <= wr_data[8*off[1:0] +: 8];
            end
        end
    end

    for (genvar j = 0; j < 4; j++) begin : g_lane
        assign rd_data[8*j +: 8] = mem[rd_base + IDX_W'(j)];
    end

endmodule

// File: rtl/aprom_io_decoder.sv
module aprom_io_decoder
    import aprom_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter int          WIN_BYTES    = 16,
    parameter logic [47:0] STATION_ADDR = 48'h6655_4433_2211,
    parameter logic [7:0]  FILL_BYTE    = 8'h57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic              mode32,
    input  logic              prom_wr_en,
    output logic              rsp_ready,
    output logic [31:0]       rsp_rdata,
    output logic              reg_req,
    output logic              reg_write,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [1:0]        reg_size,
    output logic [31:0]       reg_wdata,
    input  logic              reg_ready,
    input  logic [31:0]       reg_rdata
);
    localparam int IDX_W = $clog2(WIN_BYTES);

    dec_state_t        state, state_nx;
    acc_size_t         sz;
    acc_class_t        cls;
    logic              accept;
    logic              hit_fwd;
    logic [3:0]        wr_lanes;
    logic [31:0]       prom_rd;
    logic              fwd_write_q;
    logic [ADDR_W-1:0] fwd_addr_q;
    logic [1:0]        fwd_size_q;
    logic [31:0]       fwd_wdata_q;
    logic [31:0]       rdata_q;

    assign sz      = acc_size_t'(req_size);
    assign accept  = req_valid && (state == ST_IDLE);
    assign hit_fwd = (cls == CLS_FWD);

    aprom_classify #(
        .ADDR_W    (ADDR_W),
        .WIN_BYTES (WIN_BYTES)
    ) i_classify (
        .addr   (req_addr),
        .size   (sz),
        .mode32 (mode32),
        .cls    (cls)
    );

    assign wr_lanes = (accept && req_write && cls == CLS_PROM && prom_wr_en)
                      ? lane_mask(sz) : 4'b0000;

    aprom_store #(
        .WIN_BYTES    (WIN_BYTES),
        .STATION_ADDR (STATION_ADDR),
        .FILL_BYTE    (FILL_BYTE)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_base  (req_addr[IDX_W-1:0]),
        .wr_lanes (wr_lanes),
        .wr_data  (req_wdata),
        .rd_base  (req_addr[IDX_W-1:0]),
        .rd_data  (prom_rd)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nx = hit_fwd ? ST_FWD : ST_RESP;
                end
            end
            ST_FWD: begin
                if (reg_ready) begin
                    state_nx = ST_RESP;
                end
            end
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Captured request and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_write_q <= 1'b0;
            fwd_addr_q  <= '0;
            fwd_size_q  <= 2'b00;
            fwd_wdata_q <= '0;
            rdata_q     <= '0;
        end else if (accept) begin
            fwd_write_q <= req_write;
            fwd_addr_q  <= req_addr;
            fwd_size_q  <= req_size;
            fwd_wdata_q <= req_wdata & width_mask(sz);
            if (req_write) begin
                rdata_q <= '0;
            end else if (cls == CLS_PROM) begin
                rdata_q <= prom_rd & width_mask(sz);
            end else if (cls == CLS_NONE) begin
                rdata_q <= width_mask(sz);
            end else begin
                rdata_q <= '0;
            end
        end else if (state == ST_FWD && reg_ready && !fwd_write_q) begin
            rdata_q <= reg_rdata & width_mask(acc_size_t'(fwd_size_q));
        end
    end

    // Outputs
    always_comb begin
        rsp_ready = (state == ST_RESP);
        rsp_rdata = rdata_q;
        reg_req   = (state == ST_FWD);
        reg_write = fwd_write_q;
        reg_addr  = fwd_addr_q;
        reg_size  = fwd_size_q;
        reg_wdata = fwd_wdata_q;
    end

endmodule

// File: rtl/aprom_io_decoder_chk.sv
module aprom_io_decoder_chk #(
    parameter int ADDR_W    = 8,
    parameter int WIN_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept,
    input logic              hit_fwd,
    input logic              prom_wr,
    input logic              req_write,
    input logic              prom_wr_en,
    input logic              rsp_ready,
    input logic              reg_req,
    input logic              reg_ready,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [1:0]        reg_size,
    input logic [31:0]       reg_wdata
);
    localparam int WIN_IDX_W = $clog2(WIN_BYTES);

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready); // R10

    AST_LOCAL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !hit_fwd |=> rsp_ready && !reg_req); // R10

    AST_FWD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        accept && hit_fwd |=> reg_req && !rsp_ready); // R8

    AST_FWD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> (reg_size == 2'b01 || reg_size == 2'b10)
                    && ((reg_addr >> WIN_IDX_W) != '0)); // R8

    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_ready |=> reg_req && $stable(reg_addr) && $stable(reg_size)
                                  && $stable(reg_write) && $stable(reg_wdata)); // R9

    AST_FWD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && reg_ready |=> rsp_ready && !reg_req); // R9

    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        prom_wr |-> prom_wr_en && req_write && !hit_fwd); // R6

endmodule

bind aprom_io_decoder aprom_io_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .WIN_BYTES (WIN_BYTES)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .hit_fwd    (hit_fwd),
    .prom_wr    (|wr_lanes),
    .req_write  (req_write),
    .prom_wr_en (prom_wr_en),
    .rsp_ready  (rsp_ready),
    .reg_req    (reg_req),
    .reg_ready  (reg_ready),
    .reg_write  (reg_write),
    .reg_addr   (reg_addr),
    .reg_size   (reg_size),
    .reg_wdata  (reg_wdata)
);

// File: tb/test_aprom_io_decoder.sv
`timescale 1ns/1ps
module test_aprom_io_decoder;
    localparam int          ADDR_W = 8;
    localparam logic [47:0] SA     = 48'h6655_4433_2211;
    localparam logic [7:0]  FILL   = 8'h57;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'b00;
    logic [31:0]       req_wdata = '0;
    logic              mode32 = 1'b0;
    logic              prom_wr_en = 1'b0;
    logic              rsp_ready;
    logic [31:0]       rsp_rdata;
    logic              reg_req;
    logic              reg_write;
    logic [ADDR_W-1:0] reg_addr;
    logic [1:0]        reg_size;
    logic [31:0]       reg_wdata;
    logic              reg_ready = 1'b0;
    logic [31:0]       reg_rdata = '0;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] model [16];

    always #2.5 clk = ~clk;

    aprom_io_decoder #(
        .ADDR_W       (ADDR_W),
        .WIN_BYTES    (16),
        .STATION_ADDR (SA),
        .FILL_BYTE    (FILL)
    ) i_aprom_io_decoder (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_size (req_size), .req_wdata (req_wdata), .mode32 (mode32),
        .prom_wr_en (prom_wr_en), .rsp_ready (rsp_ready), .rsp_rdata (rsp_rdata),
        .reg_req (reg_req), .reg_write (reg_write), .reg_addr (reg_addr),
        .reg_size (reg_size), .reg_wdata (reg_wdata),
        .reg_ready (reg_ready), .reg_rdata (reg_rdata)
    );

    function automatic logic [31:0] wmask(input logic [1:0] s);
        if (s == 2'b00) return 32'hFF;
        if (s == 2'b01) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic int nbytes(input logic [1:0] s);
        if (s == 2'b00) return 1;
        if (s == 2'b01) return 2;
        if (s == 2'b10) return 4;
        return 0;
    endfunction

    // 0 = not served, 1 = PROM, 2 = forwarded
    function automatic int exp_class(input logic [7:0] a, input logic [1:0] s, input logic m);
        if (a < 8'h10) begin
            if (!m && s == 2'b00) return 1;
            if (!m && s == 2'b01 && a[0] == 1'b0) return 1;
            if (m && s == 2'b10 && a[1:0] == 2'b00) return 1;
            return 0;
        end
        if (s == 2'b01 || s == 2'b10) return 2;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [1:0] s,
                          input logic [31:0] wd, input logic m, input logic we);
        int cls;
        int dly;
        int cnt;
        int waited;
        bit seen;
        logic [31:0] rr;
        logic [31:0] expv;
        string tg;
        cls = exp_class(a, s, m);
        dly = $urandom_range(0, 3);
        rr = $urandom;
        cnt = 0;
        waited = 0;
        seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = s;
        req_wdata = wd; mode32 = m; prom_wr_en = we;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_ready && waited < 40) begin
            reg_ready = 1'b0;
            if (reg_req) begin
                if (!seen) begin
                    chk(reg_addr == a, "R8 addr", 32'(reg_addr), 32'(a));
                    chk(reg_size == s, "R8 size", 32'(reg_size), 32'(s));
                    chk(reg_write == wr, "R8 write", 32'(reg_write), 32'(wr));
                    if (wr) chk(reg_wdata == (wd & wmask(s)), "R8 wdata", reg_wdata, wd & wmask(s));
                end
                seen = 1;
                if (cnt == dly) begin
                    reg_ready = 1'b1;
                    reg_rdata = rr;
                end
                cnt++;
            end
            @(negedge clk);
            waited++;
        end
        reg_ready = 1'b0;
        chk(rsp_ready == 1'b1, "R10 response", 32'(rsp_ready), 32'd1);
        if (cls != 2) chk(waited == 0, "R10 latency", 32'(waited), 32'd0);
        else chk(waited == dly + 1, "R9 latency", 32'(waited), 32'(dly + 1));
        chk(seen == (cls == 2), "R8 forwarded", 32'(seen), 32'(cls == 2));
        if (!wr) begin
            if (cls == 1) begin
                expv = '0;
                for (int j = 0; j < nbytes(s); j++) expv[8*j +: 8] = model[(a + j) & 15];
                tg = "R5 PROM read";
            end else if (cls == 0) begin
                expv = wmask(s);
                tg = "R7 unserved read";
            end else begin
                expv = rr & wmask(s);
                tg = "R9 forwarded read";
            end
            chk(rsp_rdata == expv, tg, rsp_rdata, expv);
        end else if (cls == 1 && we) begin
            for (int j = 0; j < nbytes(s); j++) model[(a + j) & 15] = wd[8*j +: 8];
        end
        @(negedge clk);
        chk(rsp_ready == 1'b0, "R10 pulse", 32'(rsp_ready), 32'd0);
    endtask

    initial begin
        #500000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        for (int b = 0; b < 16; b++) model[b] = (b < 6) ? 8'(SA >> (8 * b)) : FILL;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_ready == 1'b0 && reg_req == 1'b0, "R1 idle outputs", {rsp_ready, reg_req}, 32'd0);
        // R1, R2: reset contents, byte reads at every offset
        for (int b = 0; b < 16; b++) access(1'b0, 8'(b), 2'b00, 0, 1'b0, 1'b0);
        // R5: little-endian assembly
        access(1'b0, 8'h04, 2'b01, 0, 1'b0, 1'b0);
        access(1'b0, 8'h08, 2'b10, 0, 1'b1, 1'b0);
        // R3: odd half in 16-bit mode
        access(1'b0, 8'h03, 2'b01, 0, 1'b0, 1'b0);
        // R4: wrong size or alignment in 32-bit mode
        access(1'b0, 8'h04, 2'b00, 0, 1'b1, 1'b0);
        access(1'b0, 8'h04, 2'b01, 0, 1'b1, 1'b0);
        access(1'b0, 8'h06, 2'b10, 0, 1'b1, 1'b0);
        access(1'b0, 8'h04, 2'b10, 0, 1'b0, 1'b0);
        // R7: reserved size code
        access(1'b0, 8'h02, 2'b11, 0, 1'b0, 1'b0);
        access(1'b0, 8'h40, 2'b11, 0, 1'b0, 1'b0);
        // R6: gated write dropped, then enabled word write split
        access(1'b1, 8'h00, 2'b10, 32'hDEAD_BEEF, 1'b1, 1'b0);
        access(1'b0, 8'h00, 2'b10, 0, 1'b1, 1'b0);
        access(1'b1, 8'h0C, 2'b10, 32'hA1B2_C3D4, 1'b1, 1'b1);
        for (int b = 12; b < 16; b++) access(1'b0, 8'(b), 2'b00, 0, 1'b0, 1'b0);
        // R11: rejected writes with enable high
        access(1'b1, 8'h05, 2'b01, 32'h0000_9999, 1'b0, 1'b1);
        access(1'b1, 8'h02, 2'b10, 32'h7777_7777, 1'b1, 1'b1);
        access(1'b1, 8'h08, 2'b11, 32'h5555_5555, 1'b0, 1'b1);
        for (int b = 0; b < 12; b++) access(1'b0, 8'(b), 2'b00, 0, 1'b0, 1'b0);
        // R8, R9: forwarded and non-forwarded accesses above the window
        access(1'b0, 8'h20, 2'b01, 0, 1'b0, 1'b0);
        access(1'b1, 8'h44, 2'b10, 32'h1234_5678, 1'b1, 1'b0);
        access(1'b1, 8'h31, 2'b01, 32'hFFFF_ABCD, 1'b0, 1'b0);
        access(1'b0, 8'h30, 2'b00, 0, 1'b0, 1'b0);
        access(1'b1, 8'h30, 2'b00, 32'h0000_0011, 1'b0, 1'b1);
        access(1'b0, 8'h10, 2'b10, 0, 1'b1, 1'b0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] ra;
            ra = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
            access(1'($urandom), ra, 2'($urandom), $urandom, 1'($urandom), 1'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule